// File: doc/BRIEF.md
# Multi-Rail Voltage Command Scheduler

This block holds the applied output-voltage target and transition-rate setting for each rail of a power controller that serves several rails over one serial link. A frame receiver hands it one decoded command per cycle: a rail select, a command code, a 16-bit data value and an execute flag. The block either applies the command at once or parks it as a pending value for that rail. It drives the applied targets to the per-rail regulation loops and returns an acknowledge code to the receiver.

A command with the execute flag clear is held. A command with the execute flag set applies its own value together with every held value on every rail in the same clock edge, so that several rails can be moved together. Voltage values are 1 mV per LSB, giving 0 to 65.535 V. Transition-rate values are 1 mV/us per LSB.

Top module: `rail_cmd_sched`

## Requirements
- R1: While `rst_ni` is low and after it is released, every rail's `vout_o` field equals `DEF_VOUT_MV` and every `slew_o` field equals `DEF_SLEW`. No value is pending and `rsp_valid_o` is 0.
- R2: An accepted command with `cmd_exec_i`=1 and code 0 sets the addressed rail's 16-bit voltage field to `cmd_data_i`, and code 1 sets its rate field. Rail i occupies bits [16i+15:16i]. Any value from 0 to 65535 is carried unchanged.
- R3: An accepted command with `cmd_exec_i`=0 stores its value as pending for the addressed rail and field and leaves all outputs unchanged.
- R4: An accepted execute command loads every pending value on every rail into its output in the same edge as its own value, then clears all pending values. On the same rail and field, the command's own value takes precedence over a pending one.
- R5: A second held command to the same rail and field before a commit replaces the earlier pending value.
- R6: Code 2 sets the addressed rail's voltage to `DEF_VOUT_MV`, either at once or as a pending value according to `cmd_exec_i`.
- R7: Rail select 15 addresses every implemented rail. Values 0 to 14 address one rail each.
- R8: A rail select of at least `NUM_RAILS` and not 15 returns acknowledge 2'b11. It changes no output and no pending value.
- R9: Command code 3 on a valid rail returns acknowledge 2'b01 and changes nothing.
- R10: Each command with `cmd_valid_i` high gives `rsp_valid_o` high on the next cycle, with acknowledge 2'b00 when the command was accepted. Otherwise `rsp_valid_o` is low.
- R11: In a cycle with no valid command, no output field changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Decoded command present this cycle |
| cmd_rail_i | input | 4 | Rail select, 15 = all rails |
| cmd_code_i | input | 2 | 0 voltage, 1 rate, 2 voltage reset, 3 unsupported |
| cmd_data_i | input | 16 | Voltage (1 mV/LSB) or rate (1 mV/us per LSB) |
| cmd_exec_i | input | 1 | 1 = execute and commit all pending, 0 = hold |
| vout_o | output | 16*NUM_RAILS | Applied voltage targets, rail i at [16i+15:16i] |
| slew_o | output | 16*NUM_RAILS | Applied transition rates, same layout |
| rsp_valid_o | output | 1 | Acknowledge valid, one cycle after the command |
| rsp_ack_o | output | 2 | 00 ok, 01 unsupported code, 11 bad rail select |

## Verification
The bench holds values on some rails and commits them with an execute aimed at a different rail. A design that committed only the addressed rail would leave those rails at their old values. Further checks cover a held rate command colliding with an execute to the same field, which exposes the wrong precedence, and a commit after pending values should already have been cleared, which exposes stale values coming back. Other checks send an invalid rail between a hold and its commit, which catches a design that drops or applies pending values on a rejected command. The remaining checks cover broadcast addressing, a pending value overwritten before commit, voltage reset to the default, a full-scale value, and reset clearing pending state.

// File: rtl/rail_cmd_sched_pkg.sv
package rail_cmd_sched_pkg;
  localparam int VAL_W   = 16;
  localparam int SEL_W   = 4;
  localparam logic [SEL_W-1:0] SEL_ALL = 4'hF;

  typedef enum logic [1:0] {
    CMD_VOUT   = 2'b00,
    CMD_SLEW   = 2'b01,
    CMD_VRESET = 2'b10,
    CMD_RSVD   = 2'b11
  } cmd_code_e;

  typedef enum logic [1:0] {
    ACK_OK      = 2'b00,
    ACK_UNAVAIL = 2'b01,
    ACK_BADSEL  = 2'b11
  } ack_e;
endpackage

// File: rtl/rail_cmd_decode.sv
module rail_cmd_decode
  import rail_cmd_sched_pkg::*;
#(
  parameter int NUM_RAILS = 4
) (
  input  logic                 valid_i,
  input  logic [SEL_W-1:0]     rail_i,
  input  logic [1:0]           code_i,
  output logic [NUM_RAILS-1:0] hit_o,
  output logic                 accept_o,
  output ack_e                 ack_o
);
  logic sel_ok;
  logic code_ok;

  assign sel_ok  = (rail_i == SEL_ALL) || (int'(rail_i) < NUM_RAILS);
  assign code_ok = (code_i != CMD_RSVD);

  always_comb begin
    if (!sel_ok)       ack_o = ACK_BADSEL;
    else if (!code_ok) ack_o = ACK_UNAVAIL;
    else               ack_o = ACK_OK;
  end

  assign accept_o = valid_i && sel_ok && code_ok;

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_hit
    assign hit_o[g] = accept_o && ((rail_i == SEL_ALL) || (int'(rail_i) == g));
  end
endmodule

// File: rtl/rail_slot.sv
module rail_slot
  import rail_cmd_sched_pkg::*;
#(
  parameter logic [VAL_W-1:0] DEF_VOUT = 16'd900,
  parameter logic [VAL_W-1:0] DEF_SLEW = 16'd10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             exec_i,
  input  logic             hit_i,
  input  logic [1:0]       code_i,
  input  logic [VAL_W-1:0] data_i,
  output logic [VAL_W-1:0] vout_o,
  output logic [VAL_W-1:0] slew_o
);
  logic [VAL_W-1:0] vout_q, slew_q, pv_q, ps_q;
  logic             pv_vld_q, ps_vld_q;
  logic             wr_v, wr_s, commit;
  logic [VAL_W-1:0] val_v;

  assign wr_v   = hit_i && (code_i == CMD_VOUT || code_i == CMD_VRESET);
  assign wr_s   = hit_i && (code_i == CMD_SLEW);
  assign val_v  = (code_i == CMD_VRESET) ? DEF_VOUT : data_i;
  assign commit = accept_i && exec_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vout_q   <= DEF_VOUT;
      slew_q   <= DEF_SLEW;
      pv_q     <= '0;
      ps_q     <= '0;
      pv_vld_q <= 1'b0;
      ps_vld_q <= 1'b0;
    end else if (commit) begin
      // own value wins over a pending one on the same field
      if (wr_v)          vout_q <= val_v;
      else if (pv_vld_q) vout_q <= pv_q;
      if (wr_s)          slew_q <= data_i;
      else if (ps_vld_q) slew_q <= ps_q;
      pv_vld_q <= 1'b0;
      ps_vld_q <= 1'b0;
    end else if (accept_i) begin
      if (wr_v) begin
        pv_q     <= val_v;
        pv_vld_q <= 1'b1;
      end
      if (wr_s) begin
        ps_q     <= data_i;
        ps_vld_q <= 1'b1;
      end
    end
  end

  assign vout_o = vout_q;
  assign slew_o = slew_q;
endmodule

// File: rtl/rail_cmd_sched.sv
module rail_cmd_sched
  import rail_cmd_sched_pkg::*;
#(
  parameter int NUM_RAILS = 4,
  parameter logic [15:0] DEF_VOUT_MV = 16'd900,
  parameter logic [15:0] DEF_SLEW    = 16'd10
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cmd_valid_i,
  input  logic [3:0]                 cmd_rail_i,
  input  logic [1:0]                 cmd_code_i,
  input  logic [15:0]                cmd_data_i,
  input  logic                       cmd_exec_i,
  output logic [NUM_RAILS*16-1:0]    vout_o,
  output logic [NUM_RAILS*16-1:0]    slew_o,
  output logic                       rsp_valid_o,
  output logic [1:0]                 rsp_ack_o
);
  logic [NUM_RAILS-1:0] hit;
  logic                 accept;
  ack_e                 ack_d;
  logic                 rsp_valid_q;
  logic [1:0]           rsp_ack_q;

  rail_cmd_decode #(.NUM_RAILS(NUM_RAILS)) u_decode (
    .valid_i  (cmd_valid_i),
    .rail_i   (cmd_rail_i),
    .code_i   (cmd_code_i),
    .hit_o    (hit),
    .accept_o (accept),
    .ack_o    (ack_d)
  );

  for (genvar g = 0; g < NUM_RAILS; g++) begin : g_rail
    rail_slot #(.DEF_VOUT(DEF_VOUT_MV), .DEF_SLEW(DEF_SLEW)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .accept_i (accept),
      .exec_i   (cmd_exec_i),
      .hit_i    (hit[g]),
      .code_i   (cmd_code_i),
      .data_i   (cmd_data_i),
      .vout_o   (vout_o[g*VAL_W +: VAL_W]),
      .slew_o   (slew_o[g*VAL_W +: VAL_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rsp_ack_q   <= ACK_OK;
    end else begin
      rsp_valid_q <= cmd_valid_i;
      if (cmd_valid_i) rsp_ack_q <= ack_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_ack_o   = rsp_ack_q;
endmodule

// File: rtl/rail_cmd_sched_chk.sv
module rail_cmd_sched_chk #(
  parameter int NUM_RAILS = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    cmd_valid_i,
  input logic [3:0]              cmd_rail_i,
  input logic [1:0]              cmd_code_i,
  input logic [15:0]             cmd_data_i,
  input logic                    cmd_exec_i,
  input logic [NUM_RAILS*16-1:0] vout_o,
  input logic [NUM_RAILS*16-1:0] slew_o,
  input logic                    rsp_valid_o,
  input logic [1:0]              rsp_ack_o
);
  logic bad_sel;
  assign bad_sel = (cmd_rail_i != 4'hF) && (int'(cmd_rail_i) >= NUM_RAILS);

  assert_hold_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !cmd_exec_i |=> $stable(vout_o) && $stable(slew_o));

  assert_badsel_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && bad_sel |=> $stable(vout_o) && $stable(slew_o) && rsp_ack_o == 2'b11);

  assert_rsvd_code_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && !bad_sel && cmd_code_i == 2'b11 |=> $stable(vout_o) && rsp_ack_o == 2'b01);

  assert_rsp_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> rsp_valid_o);

  assert_rsp_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !rsp_valid_o);

  assert_idle_stable_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(vout_o) && $stable(slew_o));

  assert_exec_rail0_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_exec_i && cmd_rail_i == 4'd0 && cmd_code_i == 2'b00
    |=> vout_o[15:0] == $past(cmd_data_i));
endmodule

bind rail_cmd_sched rail_cmd_sched_chk #(.NUM_RAILS(NUM_RAILS)) u_chk (.*);

// File: tb/rail_cmd_sched_tb.sv
module rail_cmd_sched_tb;
  localparam int NR = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            cmd_valid_i = 1'b0;
  logic [3:0]      cmd_rail_i = '0;
  logic [1:0]      cmd_code_i = '0;
  logic [15:0]     cmd_data_i = '0;
  logic            cmd_exec_i = 1'b0;
  logic [NR*16-1:0] vout_o, slew_o;
  logic            rsp_valid_o;
  logic [1:0]      rsp_ack_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  rail_cmd_sched #(.NUM_RAILS(NR), .DEF_VOUT_MV(16'd900), .DEF_SLEW(16'd10)) u_dut (.*);

  typedef struct packed {
    logic        vld;
    logic        ex;
    logic [3:0]  rail;
    logic [1:0]  code;
    logic [15:0] data;
    logic [1:0]  chk;
    logic [15:0] ev;
    logic [15:0] es;
    logic [1:0]  eack;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1,1'b1,4'd0,2'd0,16'd1000, 2'd0,16'd1000,16'd10,2'd0}, // R2 execute vout
    '{1'b1,1'b0,4'd1,2'd0,16'd1100, 2'd1,16'd900, 16'd10,2'd0}, // R3 hold
    '{1'b1,1'b0,4'd2,2'd1,16'd25,   2'd2,16'd900, 16'd10,2'd0}, // R3 hold slew
    '{1'b1,1'b1,4'd3,2'd0,16'd1300, 2'd1,16'd1100,16'd10,2'd0}, // R4 commit rail1
    '{1'b0,1'b0,4'd0,2'd0,16'd0,    2'd2,16'd900, 16'd25,2'd0}, // R4 commit rail2
    '{1'b0,1'b0,4'd0,2'd0,16'd0,    2'd3,16'd1300,16'd10,2'd0}, // R2 own rail3
    '{1'b1,1'b0,4'd0,2'd0,16'd1500, 2'd0,16'd1000,16'd10,2'd0}, // R3
    '{1'b1,1'b0,4'd0,2'd0,16'd1600, 2'd0,16'd1000,16'd10,2'd0}, // R5 overwrite
    '{1'b1,1'b1,4'd1,2'd1,16'd40,   2'd0,16'd1600,16'd10,2'd0}, // R5 last pending wins
    '{1'b0,1'b0,4'd0,2'd0,16'd0,    2'd1,16'd1100,16'd40,2'd0}, // R2 slew
    '{1'b1,1'b1,4'd7,2'd0,16'd5,    2'd0,16'd1600,16'd10,2'd3}, // R8 bad rail
    '{1'b1,1'b1,4'd15,2'd0,16'd700, 2'd2,16'd700, 16'd25,2'd0}, // R7 broadcast
    '{1'b1,1'b0,4'd2,2'd2,16'd0,    2'd2,16'd700, 16'd25,2'd0}, // R6 held reset
    '{1'b1,1'b1,4'd3,2'd1,16'd99,   2'd2,16'd900, 16'd25,2'd0}, // R6 reset applied
    '{1'b1,1'b1,4'd1,2'd3,16'd1,    2'd1,16'd700, 16'd40,2'd1}, // R9 reserved
    '{1'b1,1'b0,4'd15,2'd1,16'd7,   2'd0,16'd700, 16'd10,2'd0}, // R7 held bcast
    '{1'b1,1'b1,4'd0,2'd1,16'd8,    2'd0,16'd700, 16'd8, 2'd0}, // R4 own wins
    '{1'b0,1'b0,4'd0,2'd0,16'd0,    2'd3,16'd700, 16'd7, 2'd0}, // R7 bcast commit
    '{1'b1,1'b0,4'd1,2'd0,16'd1234, 2'd1,16'd700, 16'd7, 2'd0}, // R3
    '{1'b1,1'b1,4'd9,2'd0,16'd1,    2'd1,16'd700, 16'd7, 2'd3}, // R8 keeps pending
    '{1'b1,1'b1,4'd0,2'd0,16'd700,  2'd1,16'd1234,16'd7, 2'd0}, // R8 pending survived
    '{1'b1,1'b0,4'd3,2'd0,16'd2222, 2'd3,16'd700, 16'd7, 2'd0}, // R3
    '{1'b1,1'b1,4'd0,2'd0,16'd1,    2'd3,16'd2222,16'd7, 2'd0}, // R4
    '{1'b1,1'b1,4'd3,2'd0,16'd3333, 2'd3,16'd3333,16'd7, 2'd0}, // R2
    '{1'b1,1'b1,4'd0,2'd0,16'd2,    2'd3,16'd3333,16'd7, 2'd0}, // R4 pending cleared
    '{1'b1,1'b1,4'd3,2'd0,16'hFFFF, 2'd3,16'hFFFF,16'd7, 2'd0}, // R2 full scale
    '{1'b1,1'b1,4'd0,2'd0,16'd0,    2'd0,16'd0,   16'd8, 2'd0}  // R2 zero
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic ex, input logic [3:0] r,
                      input logic [1:0] c, input logic [15:0] d);
    cmd_valid_i = v; cmd_exec_i = ex; cmd_rail_i = r; cmd_code_i = c; cmd_data_i = d;
    @(negedge clk_i);
    cmd_valid_i = 1'b0;
  endtask

  initial begin
    #100000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    for (int i = 0; i < NR; i++) begin
      check("R1 vout in reset", 32'(vout_o[i*16 +: 16]), 32'd900);
      check("R1 slew in reset", 32'(slew_o[i*16 +: 16]), 32'd10);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 rsp_valid after reset", 32'(rsp_valid_o), 32'd0);

    for (int k = 0; k < NV; k++) begin
      step(VEC[k].vld, VEC[k].ex, VEC[k].rail, VEC[k].code, VEC[k].data);
      check($sformatf("R2/R4 vec%0d vout", k), 32'(vout_o[VEC[k].chk*16 +: 16]), 32'(VEC[k].ev));
      check($sformatf("R2/R4 vec%0d slew", k), 32'(slew_o[VEC[k].chk*16 +: 16]), 32'(VEC[k].es));
      check($sformatf("R10 vec%0d rsp_valid", k), 32'(rsp_valid_o), 32'(VEC[k].vld));
      if (VEC[k].vld)
        check($sformatf("R10 vec%0d ack", k), 32'(rsp_ack_o), 32'(VEC[k].eack));
    end

    // R11: idle cycles leave every field alone
    begin
      logic [NR*16-1:0] sv, ss;
      sv = vout_o; ss = slew_o;
      repeat (4) @(negedge clk_i);
      check("R11 idle vout", 32'(vout_o == sv), 32'd1);
      check("R11 idle slew", 32'(slew_o == ss), 32'd1);
    end

    // R1: reset clears pending values
    step(1'b1, 1'b0, 4'd2, 2'd0, 16'd2000);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check("R1 async reset vout", 32'(vout_o[0 +: 16]), 32'd900);
    rst_ni = 1'b1;
    @(negedge clk_i);
    step(1'b1, 1'b1, 4'd0, 2'd0, 16'd900);
    check("R1 pending cleared by reset", 32'(vout_o[2*16 +: 16]), 32'd900);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule